// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block gathers single-cycle event pulses from the rest of a network controller into a 32-bit interrupt status register. Four of the bits record transmit descriptor completions, one per priority queue. Each of these pulses fires once a descriptor that asked for an interrupt has been written back. The remaining low bits are generic event inputs. A status bit latches its event whether or not the matching mask bit is enabled. This lets software see every pending cause, including causes it has chosen not to be interrupted by.

A separate 32-bit mask register selects which pending bits drive the interrupt output. The output is registered and goes active when any status bit and its mask bit are both set.

Software reaches both registers through a simple register port. A read of the status register returns the value held at that moment, and every pending bit clears at the following clock edge. An event that arrives in the same cycle as that read is kept, so it is not lost. Writes to the status register are ignored.

Top module: `intr_status_unit`

## Requirements
- R1: After the asynchronous reset `rst_n` or a cycle of the synchronous `soft_rst`, the status register reads 0x00608000, the mask register reads 0 and `irq` is low.
- R2: An event pulse sets its status bit at the next clock edge whatever the state of the mask bit, and the bit stays set until a clearing read or a reset.
- R3: A pulse on `txq_done[q]` for queue q (0..3) sets status bit 27+q.
- R4: A pulse on `gen_evt[i]` (i in 0..26) sets status bit i.
- R5: Status bit 31 always reads 0.
- R6: With `reg_rd` high and `reg_addr` = 0x10, `reg_rdata` shows the current status in the same cycle, and all status bits clear at that clock edge.
- R7: An event pulse present in the same cycle as a clearing read is set in the status register after that edge.
- R8: A write (`reg_wr` high) to address 0x10 leaves the status register unchanged.
- R9: The mask register at address 0x14 is written with `reg_wdata` when `reg_wr` is high and reads back through `reg_rdata` when `reg_rd` is high.
- R10: `irq` is high in the cycle after an edge where (status AND mask) was nonzero, and low in the cycle after an edge where it was zero.
- R11: A read of any address other than 0x10 and 0x14 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| txq_done | input | 4 | Per-queue transmit descriptor completion pulses |
| gen_evt | input | 27 | Generic event pulses for status bits 26..0 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Registered interrupt output, active high |

## Verification
Read data is combinational, so the bench compares it 1 ns after driving a read in the low half of the clock. The effects of an event, a clear or a mask write appear in the status and mask registers after the next rising edge. `irq` follows one edge later than the status change, because it is registered from the status and mask values held before that edge. The bench drives all inputs on the falling edge and advances its model at each rising edge. It compares `irq` on the following falling edge, so every check falls exactly one register stage behind the stimulus that caused it.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int NUM_TXQ    = 4;
  localparam int TXQ_LSB    = 27;
  localparam int GEN_W      = TXQ_LSB;
  localparam int RSV_BIT    = TXQ_LSB + NUM_TXQ;
  localparam logic [DATA_W-1:0] STATUS_RST = 32'h0060_8000;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 8'h10;
  localparam logic [ADDR_W-1:0] MASK_OFS   = 8'h14;

  typedef logic [DATA_W-1:0] word_t;

  // Place queue and generic pulses at their status bit positions.
  function automatic word_t pack_events(input logic [NUM_TXQ-1:0] tx,
                                        input logic [GEN_W-1:0] gen);
    word_t w;
    w = '0;
    w[GEN_W-1:0] = gen;
    w[TXQ_LSB +: NUM_TXQ] = tx;
    return w;
  endfunction

  // Value of one status bit after an edge.
  function automatic logic bit_next(input logic cur, input logic evt,
                                    input logic clr);
    return (clr ? 1'b0 : cur) | evt;
  endfunction

  // Pending and enabled causes.
  function automatic logic any_pending(input word_t st, input word_t mk);
    return |(st & mk);
  endfunction
endpackage

// File: rtl/isr_event_latch.sv
module isr_event_latch
  import isr_pkg::*;
#(
  parameter int W = DATA_W,
  parameter logic [W-1:0] RST_VAL = STATUS_RST,
  parameter int ZERO_BIT = RSV_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == ZERO_BIT) begin : g_rsv
      assign q[i] = 1'b0;
    end else begin : g_live
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        b <= RST_VAL[i];
        else if (soft_rst) b <= RST_VAL[i];
        else               b <= bit_next(b, evt[i], clr);
      end
      assign q[i] = b;
    end
  end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg
  import isr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_rst) q <= '0;
    else if (we)       q <= wdata;
  end
endmodule

// File: rtl/isr_irq_out.sv
module isr_irq_out
  import isr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  word_t status,
  input  word_t mask,
  output logic  irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (soft_rst) irq <= 1'b0;
    else               irq <= any_pending(status, mask);
  end
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import isr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NUM_TXQ-1:0]  txq_done,
  input  logic [GEN_W-1:0]    gen_evt,
  input  logic                reg_rd,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  // Named internal events, observed by the bound checker.
  word_t evt_vec;
  logic  hit_status, hit_mask;
  logic  rd_clear, wr_status_ign, mask_we;
  word_t status_q, mask_q;

  assign evt_vec       = pack_events(txq_done, gen_evt);
  assign hit_status    = (reg_addr == STATUS_OFS);
  assign hit_mask      = (reg_addr == MASK_OFS);
  assign rd_clear      = reg_rd & hit_status;
  assign wr_status_ign = reg_wr & hit_status;
  assign mask_we       = reg_wr & hit_mask;

  isr_event_latch #(.W(DATA_W), .RST_VAL(STATUS_RST), .ZERO_BIT(RSV_BIT)) u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .evt(evt_vec), .clr(rd_clear), .q(status_q)
  );

  isr_mask_reg #(.W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .we(mask_we), .wdata(reg_wdata), .q(mask_q)
  );

  isr_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .status(status_q), .mask(mask_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_status)    reg_rdata = status_q;
      else if (hit_mask) reg_rdata = mask_q;
    end
  end
endmodule

// File: rtl/isr_checker.sv
module isr_checker
  import isr_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  soft_rst,
  input word_t evt_vec,
  input logic  rd_clear,
  input logic  wr_status_ign,
  input word_t status_q,
  input word_t mask_q,
  input logic  irq
);
  p_soft_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status_q == STATUS_RST) && (mask_q == '0) && !irq);

  // R2, R3, R4: every pulsed bit is set after the edge.
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && (evt_vec != '0)) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[RSV_BIT] == 1'b0);

  // R6 and R7: a clearing read leaves only the same-cycle events.
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !soft_rst) |=> (status_q == $past(evt_vec)));

  p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status_ign && !rd_clear && !soft_rst && (evt_vec == '0)) |=> $stable(status_q));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (irq == (|($past(status_q) & $past(mask_q)))));
endmodule

bind intr_status_unit isr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .evt_vec(evt_vec), .rd_clear(rd_clear), .wr_status_ign(wr_status_ign),
  .status_q(status_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/intr_status_unit_tb.sv
module intr_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [3:0]  txq_done = '0;
  logic [26:0] gen_evt = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_st, m_mk;
  logic        m_irq;

  localparam logic [7:0] A_ST = 8'h10, A_MK = 8'h14;

  intr_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .txq_done(txq_done),
    .gen_evt(gen_evt), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] evts(input logic [3:0] t, input logic [26:0] g);
    return {1'b0, t, g};
  endfunction

  function automatic logic [31:0] exp_rd(input logic rd, input logic [7:0] a,
                                         input logic [31:0] st, input logic [31:0] mk);
    if (!rd) return 32'h0;
    if (a == A_ST) return st;
    if (a == A_MK) return mk;
    return 32'h0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check read data, model the edge, check irq.
  task automatic cyc(input string tag, input logic rd, input logic wr,
                     input logic [7:0] a, input logic [31:0] wd,
                     input logic [3:0] t, input logic [26:0] g, input logic sr);
    logic [31:0] ex;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    txq_done = t; gen_evt = g; soft_rst = sr;
    #1;
    if (rd) begin
      ex = exp_rd(rd, a, m_st, m_mk);
      chk(reg_rdata == ex, tag, reg_rdata, ex);
    end
    @(posedge clk);
    if (sr) begin
      m_st = 32'h0060_8000; m_mk = '0; m_irq = 1'b0;
    end else begin
      m_irq = |(m_st & m_mk);
      m_st  = (((rd && a == A_ST) ? 32'h0 : m_st) | evts(t, g)) & 32'h7FFF_FFFF;
      if (wr && a == A_MK) m_mk = wd;
    end
    @(negedge clk);
    chk(irq == m_irq, {tag, " R10 irq"}, {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 1'b0, 8'h0, 32'h0, 4'h0, 27'h0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 32'h0060_8000; m_mk = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    cyc("R1 status reset", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    cyc("R1 mask reset", 1'b1, 1'b0, A_MK, 32'h0, 4'h0, 27'h0, 1'b0);
    cyc("R6 cleared", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    // R3: each queue to its bit, mask off (R2)
    for (int q = 0; q < 4; q++) begin
      cyc("R3 pulse", 1'b0, 1'b0, 8'h0, 32'h0, 4'(1 << q), 27'h0, 1'b0);
      cyc("R3 R2 queue bit", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    end
    // R4: generic bits at both ends
    cyc("R4 pulse", 1'b0, 1'b0, 8'h0, 32'h0, 4'h0, 27'h400_0001, 1'b0);
    idle("R2 hold");
    cyc("R4 generic bits", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    // R9 mask write/read, R10 irq with mask
    cyc("R9 mask write", 1'b0, 1'b1, A_MK, 32'hFFFF_FFFF, 4'h0, 27'h0, 1'b0);
    cyc("R9 mask read", 1'b1, 1'b0, A_MK, 32'h0, 4'h0, 27'h0, 1'b0);
    cyc("R10 event", 1'b0, 1'b0, 8'h0, 32'h0, 4'h8, 27'h0, 1'b0);
    idle("R10 rise");
    idle("R10 high");
    // R7: event in the clearing read cycle
    cyc("R7 read with event", 1'b1, 1'b0, A_ST, 32'h0, 4'h2, 27'h10, 1'b0);
    cyc("R7 event kept", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    idle("R10 fall");
    // R8: status write ignored
    cyc("R8 seed", 1'b0, 1'b0, 8'h0, 32'h0, 4'h0, 27'h55, 1'b0);
    cyc("R8 write status", 1'b0, 1'b1, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    cyc("R8 write status ones", 1'b0, 1'b1, A_ST, 32'hFFFF_FFFF, 4'h0, 27'h0, 1'b0);
    cyc("R8 status unchanged", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    // R11: other addresses
    cyc("R11 other addr", 1'b1, 1'b0, 8'h0C, 32'h0, 4'h0, 27'h0, 1'b0);
    cyc("R11 other addr", 1'b1, 1'b0, 8'h18, 32'h0, 4'h0, 27'h0, 1'b0);
    // R1: soft reset
    cyc("R1 soft pre", 1'b0, 1'b0, 8'h0, 32'h0, 4'hF, 27'h7FF_FFFF, 1'b0);
    cyc("R1 soft reset", 1'b0, 1'b0, 8'h0, 32'h0, 4'h0, 27'h0, 1'b1);
    cyc("R1 status after soft", 1'b1, 1'b0, A_ST, 32'h0, 4'h0, 27'h0, 1'b0);
    cyc("R1 mask after soft", 1'b1, 1'b0, A_MK, 32'h0, 4'h0, 27'h0, 1'b0);
    // R5 plus everything: constrained random
    for (int i = 0; i < 400; i++) begin
      logic rd, wr, sr;
      logic [7:0] a;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      a   = (sel == 0) ? A_MK : (sel == 3) ? 8'($urandom) : A_ST;
      rd  = ($urandom_range(0, 3) == 0);
      wr  = ($urandom_range(0, 5) == 0);
      sr  = ($urandom_range(0, 60) == 0);
      cyc("R2 R6 R9 random", rd, wr, a, $urandom,
          4'($urandom & $urandom & $urandom),
          27'($urandom & $urandom & $urandom & $urandom), sr);
      if (rd && a == A_ST)
        chk(reg_rdata[31] == 1'b0, "R5 reserved bit", reg_rdata, m_st);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule